// File: doc/BRIEF.md
# Timer Wrap Status and Interrupt Register

This block is an 8-bit CPU-visible register that collects wrap events from three 16-bit timer counters and raises one level interrupt request per channel. Each channel owns an event flag, set by hardware when its counter wraps, and an enable bit under software control. A request is raised while both are 1.

A flag is cleared only in two steps. Software first reads the register and sees the flag at 1, then writes 0 to that bit. A zero written without that earlier read is ignored, and a 1 written to a flag never sets it. Every channel counts an upward wrap (0xFFFF to 0x0000). Channels chosen by a mask parameter also count a downward wrap (0x0000 to 0xFFFF); by default this is channel 2 alone.

The counters send one-cycle pulses for wrap events. The CPU uses a select, a read strobe, a write strobe and write data, and gets back registered read data.

Top module: `timer_wrap_status`

## Requirements
- R1: Bits 7 and 3 always read as 1, and writes to them have no effect.
- R2: After a synchronous reset, all enables and flags are 0, `irq` is 0 and `rdata` reads 0x88.
- R3: An upward wrap pulse on channel i (`wrap_up[i]`) sets the flag at bit i (bits 2..0 for channels 2..0).
- R4: A downward wrap pulse (`wrap_dn[i]`) sets flag i only when bit i of `DN_MASK` is 1; on other channels it is ignored.
- R5: A flag clears only when a read has returned it as 1 and a later write puts 0 in its bit. A zero-write with no such read leaves the flag at 1.
- R6: Writing 1 to a flag bit never sets it.
- R7: The enables sit at bits 6..4 for channels 2..0 and can be read and written. `irq[i]` is 1 exactly one cycle after flag i and enable i are both 1.
- R8: If a wrap pulse and a valid clearing write hit the same flag in the same cycle, the flag stays 1.
- R9: A zero-write to an armed flag uses up the arming even when R8 keeps the flag set. A further zero-write needs a new read first.
- R10: A read (`sel` and `rd`) loads `rdata` at that clock edge; `rdata` then holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrap_up | input | 3 | One-cycle upward wrap pulse per channel |
| wrap_dn | input | 3 | One-cycle downward wrap pulse per channel |
| sel | input | 1 | Register select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 3 | Level interrupt request per channel |

## Verification
The bench builds the block with its default parameters: three channels, with downward wraps honoured on channel 2 only. One build therefore shows both sides of R4: a downward pulse is taken on one channel and dropped on the other two. Because `rdata` is registered, every read result is checked one edge after the strobe. The set-wins and arm-consumption cases are driven as a read followed by a combined write-and-pulse cycle.

// File: rtl/tovf_pkg.sv
package tovf_pkg;
  localparam int NCH    = 3;
  localparam int REG_W  = 8;
  localparam int EN_LSB = 4;
  localparam int FL_LSB = 0;
  localparam int RSV_HI = 7;
  localparam int RSV_LO = 3;

  typedef struct packed {
    logic [NCH-1:0] en;
    logic [NCH-1:0] flg;
  } tovf_state_t;

  function automatic logic [REG_W-1:0] tovf_view(input tovf_state_t s);
    logic [REG_W-1:0] v;
    v = '0;
    v[RSV_HI] = 1'b1;
    v[RSV_LO] = 1'b1;
    v[EN_LSB +: NCH] = s.en;
    v[FL_LSB +: NCH] = s.flg;
    return v;
  endfunction
endpackage

// File: rtl/tovf_flag_cell.sv
module tovf_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic rd_hit,
  input  logic wr_hit,
  input  logic wr_bit,
  output logic flag,
  output logic armed
);
  logic zero_wr;
  logic clr;

  assign zero_wr = wr_hit & ~wr_bit & armed;
  assign clr     = zero_wr & flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (set_evt)  flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      if (zero_wr)              armed <= 1'b0;
      else if (rd_hit && flag)  armed <= 1'b1;
    end
  end

  // R5
  flag_clear_armed_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(armed && wr_hit && !wr_bit));

  // R3
  flag_set_evt_chk: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> flag);

  // R6
  flag_rise_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(set_evt));
endmodule

// File: rtl/tovf_enable_reg.sv
module tovf_enable_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_hit,
  input  logic [N-1:0] wr_en,
  output logic [N-1:0] en
);
  always_ff @(posedge clk) begin
    if (rst)         en <= '0;
    else if (wr_hit) en <= wr_en;
  end
endmodule

// File: rtl/tovf_read_port.sv
module tovf_read_port
  import tovf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_hit,
  input  tovf_state_t       st,
  output logic [REG_W-1:0]  rdata
);
  localparam tovf_state_t RST_ST = '0;

  always_ff @(posedge clk) begin
    if (rst)         rdata <= tovf_view(RST_ST);
    else if (rd_hit) rdata <= tovf_view(st);
  end

  // R1
  rsv_bits_one_chk: assert property (@(posedge clk) disable iff (rst)
    rdata[RSV_HI] && rdata[RSV_LO]);
endmodule

// File: rtl/timer_wrap_status.sv
module timer_wrap_status
  import tovf_pkg::*;
#(
  parameter logic [2:0] DN_MASK = 3'b100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] wrap_up,
  input  logic [2:0] wrap_dn,
  input  logic       sel,
  input  logic       rd,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [2:0] irq
);
  logic           rd_hit;
  logic           wr_hit;
  logic [NCH-1:0] flg;
  logic [NCH-1:0] armed;
  logic [NCH-1:0] en_q;
  tovf_state_t    st;

  assign rd_hit = sel & rd;
  assign wr_hit = sel & wr;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic set_evt;
    assign set_evt = wrap_up[i] | (wrap_dn[i] & DN_MASK[i]);

    tovf_flag_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .set_evt (set_evt),
      .rd_hit  (rd_hit),
      .wr_hit  (wr_hit),
      .wr_bit  (wdata[FL_LSB + i]),
      .flag    (flg[i]),
      .armed   (armed[i])
    );

    // R7
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
      irq[i] |-> $past(en_q[i]));
  end

  tovf_enable_reg #(.N(NCH)) u_en (
    .clk    (clk),
    .rst    (rst),
    .wr_hit (wr_hit),
    .wr_en  (wdata[EN_LSB +: NCH]),
    .en     (en_q)
  );

  assign st.en  = en_q;
  assign st.flg = flg;

  tovf_read_port u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_hit (rd_hit),
    .st     (st),
    .rdata  (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= '0;
    else     irq <= flg & en_q;
  end
endmodule

// File: tb/timer_wrap_status_bench.sv
module timer_wrap_status_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] wrap_up, wrap_dn;
  logic       sel, rd, wr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [2:0] irq;
  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  timer_wrap_status u_timer_wrap_status (
    .clk(clk), .rst(rst), .wrap_up(wrap_up), .wrap_dn(wrap_dn),
    .sel(sel), .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // {req, op, data, up, dn}; op 0 = pulse/idle, 1 = read and check, 2 = write
  localparam int NV = 20;
  localparam logic [19:0] VEC [NV] = '{
    {4'd2,  2'd1, 8'h88, 3'b000, 3'b000}, // R2 reset view
    {4'd7,  2'd2, 8'h70, 3'b000, 3'b000}, // R7 enable all
    {4'd7,  2'd1, 8'hF8, 3'b000, 3'b000},
    {4'd3,  2'd0, 8'h00, 3'b001, 3'b000}, // R3
    {4'd3,  2'd1, 8'hF9, 3'b000, 3'b000},
    {4'd5,  2'd2, 8'hF8, 3'b000, 3'b000}, // R5 armed clear
    {4'd5,  2'd1, 8'hF8, 3'b000, 3'b000},
    {4'd3,  2'd0, 8'h00, 3'b001, 3'b000},
    {4'd5,  2'd2, 8'hF8, 3'b000, 3'b000}, // R5 not armed
    {4'd5,  2'd1, 8'hF9, 3'b000, 3'b000},
    {4'd5,  2'd2, 8'hF8, 3'b000, 3'b000},
    {4'd5,  2'd1, 8'hF8, 3'b000, 3'b000},
    {4'd6,  2'd2, 8'h77, 3'b000, 3'b000}, // R6
    {4'd6,  2'd1, 8'hF8, 3'b000, 3'b000},
    {4'd4,  2'd0, 8'h00, 3'b000, 3'b011}, // R4 masked
    {4'd4,  2'd1, 8'hF8, 3'b000, 3'b000},
    {4'd4,  2'd0, 8'h00, 3'b000, 3'b100}, // R4 honoured
    {4'd4,  2'd1, 8'hFC, 3'b000, 3'b000},
    {4'd3,  2'd0, 8'h00, 3'b010, 3'b000},
    {4'd10, 2'd1, 8'hFE, 3'b000, 3'b000}  // R10
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic w, input logic [7:0] d,
                      input logic [2:0] up, input logic [2:0] dn);
    @(negedge clk);
    sel = r | w; rd = r; wr = w; wdata = d; wrap_up = up; wrap_dn = dn;
    @(negedge clk);
    sel = 0; rd = 0; wr = 0; wdata = '0; wrap_up = '0; wrap_dn = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    sel = 0; rd = 0; wr = 0; wdata = '0; wrap_up = '0; wrap_dn = '0; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2 reset state at the ports
    chk("R2 rdata", rdata, 8'h88);
    chk("R2 irq", {5'd0, irq}, 8'h00);

    for (int k = 0; k < NV; k++) begin
      logic [19:0] v;
      v = VEC[k];
      case (v[15:14])
        2'd1: begin
          step(1'b1, 1'b0, 8'h00, 3'b000, 3'b000);
          chk($sformatf("R%0d vec%0d", v[19:16], k), rdata, v[13:6]);
        end
        2'd2: step(1'b0, 1'b1, v[13:6], v[5:3], v[2:0]);
        default: step(1'b0, 1'b0, 8'h00, v[5:3], v[2:0]);
      endcase
    end

    // R1 writes to reserved bits ignored
    do_reset();
    step(1'b0, 1'b1, 8'h00, 3'b000, 3'b000);
    step(1'b1, 1'b0, 8'h00, 3'b000, 3'b000);
    chk("R1 reserved", rdata, 8'h88);

    // R7 irq gating and latency
    step(1'b0, 1'b1, 8'h10, 3'b000, 3'b000);
    step(1'b0, 1'b0, 8'h00, 3'b011, 3'b000);
    step(1'b0, 1'b0, 8'h00, 3'b000, 3'b000);
    chk("R7 irq on", {5'd0, irq}, 8'h01);
    step(1'b1, 1'b0, 8'h00, 3'b000, 3'b000);
    chk("R7 view", rdata, 8'h9B);
    step(1'b0, 1'b1, 8'h07, 3'b000, 3'b000);
    step(1'b0, 1'b0, 8'h00, 3'b000, 3'b000);
    chk("R7 irq off", {5'd0, irq}, 8'h00);
    step(1'b1, 1'b0, 8'h00, 3'b000, 3'b000);
    chk("R6 flags kept", rdata, 8'h8B);

    // R8 set wins, R9 arming consumed
    do_reset();
    step(1'b0, 1'b0, 8'h00, 3'b001, 3'b000);
    step(1'b1, 1'b0, 8'h00, 3'b000, 3'b000);
    chk("R3 set", rdata, 8'h89);
    step(1'b0, 1'b1, 8'h00, 3'b001, 3'b000);
    step(1'b0, 1'b1, 8'h00, 3'b000, 3'b000);
    step(1'b1, 1'b0, 8'h00, 3'b000, 3'b000);
    chk("R8 R9 still set", rdata, 8'h89);
    step(1'b0, 1'b1, 8'h00, 3'b000, 3'b000);
    step(1'b1, 1'b0, 8'h00, 3'b000, 3'b000);
    chk("R5 cleared", rdata, 8'h88);

    // R10 rdata holds between reads
    step(1'b0, 1'b0, 8'h00, 3'b100, 3'b000);
    chk("R10 hold", rdata, 8'h88);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule